// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a data cache placed between a 32-bit processor port and a main memory that moves one 32-bit word at a time. It keeps 1024 lines of four words each, which is 16 KB of data. Each line carries a valid flag and an 18-bit tag. A read that finds its line valid with a matching tag is answered in the same cycle. Any other read stalls the processor and brings the whole line in from memory one word at a time. The line then gets its tag and valid flag, and the stalled read is retried and hits.

Every write goes to memory through a four-entry write queue. A write that hits also updates the stored word. A write that misses leaves the cache unchanged. The processor waits on a write only when the queue is full. Before a line refill is requested, the queue is emptied, so a refill always reads data that already includes every earlier write.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` is high while no access is presented, and `mem_req` is low.
- R2: The address splits into a byte offset in bits 1:0, a word select in bits 3:2, a line index in bits 13:4 and a tag in bits 31:14. A read hits only when the indexed line is valid and its stored tag equals bits 31:14.
- R3: A read miss keeps `cpu_ready` low and then returns the memory word. If the queue is empty and the memory accepts an address in 1 cycle and returns each of the four words 15 + 1 cycles apart (65 cycles in all), the stall is exactly 67 cycles: one lookup cycle, one queue-check cycle and the 65-cycle refill.
- R4: A refill fetches the four words of the line in order (line base address with bits 3:0 zero, words at offsets 0, 4, 8 and 12), so later reads of any word in the line hit with no stall.
- R5: Two addresses with the same index and different tags evict each other, including tags that differ only in bit 31.
- R6: A write hit updates the addressed word in the cache, and a following read returns the new value with no stall.
- R7: Every accepted write reaches memory with its address and data (write-through).
- R8: A write miss does not allocate a line: a later read of that address misses and returns the written value from memory.
- R9: A refill read is issued to memory only after all queued writes have been accepted by memory.
- R10: A write stalls only while the queue holds four entries. With the queue empty and memory busy 16 cycles per accepted write, five back-to-back writes complete with no stall and a sixth stalls.
- R11: While a memory request is not granted, `mem_req`, `mem_we` and `mem_addr` stay unchanged.
- R12: The last index (1023) maps and refills like any other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Access completes in this cycle. Low while stalled |
| cpu_rdata | output | 32 | Read data, valid when `cpu_ready` is high on a read |
| mem_req | output | 1 | Memory request, held until `mem_gnt` |
| mem_we | output | 1 | 1 = single-word write, 0 = line read |
| mem_addr | output | 32 | Write address, or line base address for a read |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Memory takes the request in this cycle |
| mem_rvalid | input | 1 | A refill word is on `mem_rdata` |
| mem_rdata | input | 32 | Refill word, in ascending word order |

## Verification
The bench feeds cold reads, repeated reads within one line and reads of lines that collide on the index, including a collision only in the top tag bit. These separate a correct tag compare and refill from one that ignores tag bits or word order. Write hits, then write misses followed at once by a read of the same word, show whether the cache is updated or allocated and whether the queue is drained before the refill. A burst of six writes against a slow memory marks the exact point where the queue fills, and stall counts on misses pin the refill timing.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [1:0] {
      ST_LOOKUP,
      ST_DRAIN,
      ST_FETCH_REQ,
      ST_FETCH_DATA
   } ctl_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/wt_queue.sv
module wt_queue #(
   parameter int unsigned ENTRY_W = 64,
   parameter int unsigned DEPTH   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [ENTRY_W-1:0] push_data,
   input  logic               pop,
   output logic [ENTRY_W-1:0] head,
   output logic               empty,
   output logic               full
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   if (!dmc_pkg::is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("wt_queue: DEPTH must be a power of two of at least 2");
   end

   logic [ENTRY_W-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0]   wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == FULL_CNT);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = slot_q[rd_ptr_q];

   always_ff @(posedge clk) begin
      if (do_push) slot_q[wr_ptr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
         if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
         else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/dm_line_store.sv
module dm_line_store #(
   parameter int unsigned LINES  = 1024,
   parameter int unsigned WORDS  = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned TAG_W  = 18
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(LINES)-1:0] rd_idx,
   input  logic [$clog2(WORDS)-1:0] rd_wsel,
   output logic                     rd_valid,
   output logic [TAG_W-1:0]         rd_tag,
   output logic [DATA_W-1:0]        rd_data,
   input  logic                     wr_en,
   input  logic [$clog2(LINES)-1:0] wr_idx,
   input  logic [$clog2(WORDS)-1:0] wr_wsel,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     fill_en,
   input  logic [TAG_W-1:0]         fill_tag
);
   logic [LINES-1:0]  valid_q;
   logic [TAG_W-1:0]  tag_q [LINES];
   logic [DATA_W-1:0] word_rd [WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n)       valid_q <= '0;
      else if (fill_en) valid_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[wr_idx] <= fill_tag;
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [DATA_W-1:0] bank_q [LINES];
      always_ff @(posedge clk) begin
         if (wr_en && wr_wsel == w) bank_q[wr_idx] <= wr_data;
      end
      assign word_rd[w] = bank_q[rd_idx];
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_data  = word_rd[rd_wsel];
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache
   import dmc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned LINES    = 1024,
   parameter int unsigned WORDS    = 4,
   parameter int unsigned WB_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int unsigned BYTE_W   = $clog2(DATA_W / 8);
   localparam int unsigned WSEL_W   = $clog2(WORDS);
   localparam int unsigned IDX_W    = $clog2(LINES);
   localparam int unsigned LINE_LSB = BYTE_W + WSEL_W;
   localparam int unsigned TAG_W    = ADDR_W - IDX_W - LINE_LSB;
   localparam int unsigned ENTRY_W  = ADDR_W + DATA_W;
   localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(WORDS - 1);

   if (!is_pow2(LINES) || !is_pow2(WORDS) || WORDS < 2) begin : g_bad_geom
      $error("dm_wt_cache: LINES and WORDS must be powers of two, WORDS >= 2");
   end
   if (DATA_W % 8 != 0 || !is_pow2(DATA_W / 8)) begin : g_bad_width
      $error("dm_wt_cache: DATA_W must be a power-of-two number of bytes");
   end
   if (ADDR_W <= IDX_W + LINE_LSB) begin : g_bad_addr
      $error("dm_wt_cache: ADDR_W leaves no tag bits");
   end

   ctl_state_e          state_q, state_d;
   logic [WSEL_W-1:0]   fill_cnt_q;
   logic [IDX_W-1:0]    idx;
   logic [WSEL_W-1:0]   wsel;
   logic [TAG_W-1:0]    tag;
   logic                line_valid, hit;
   logic [TAG_W-1:0]    line_tag;
   logic                is_read, is_write, in_lookup;
   logic                wb_push, wb_pop, wb_empty, wb_full;
   logic [ENTRY_W-1:0]  wb_head;
   logic                fetch_req, fetch_beat, last_beat, wb_issue;
   logic                st_wr_en;
   logic [WSEL_W-1:0]   st_wr_wsel;
   logic [DATA_W-1:0]   st_wr_data;

   assign idx  = cpu_addr[LINE_LSB +: IDX_W];
   assign wsel = cpu_addr[BYTE_W +: WSEL_W];
   assign tag  = cpu_addr[ADDR_W-1 -: TAG_W];

   assign is_read   = cpu_req && !cpu_we;
   assign is_write  = cpu_req && cpu_we;
   assign in_lookup = (state_q == ST_LOOKUP);
   assign hit       = line_valid && (line_tag == tag);

   assign cpu_ready = in_lookup && !(is_read && !hit) && !(is_write && wb_full);
   assign wb_push   = in_lookup && is_write && !wb_full;

   assign fetch_req  = (state_q == ST_FETCH_REQ);
   assign fetch_beat = (state_q == ST_FETCH_DATA) && mem_rvalid;
   assign last_beat  = fetch_beat && (fill_cnt_q == LAST_WORD);
   assign wb_issue   = !wb_empty && (in_lookup || state_q == ST_DRAIN);
   assign wb_pop     = wb_issue && mem_gnt;

   assign mem_req   = fetch_req || wb_issue;
   assign mem_we    = !fetch_req;
   assign mem_addr  = fetch_req ? {cpu_addr[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}}
                                : wb_head[ENTRY_W-1 -: ADDR_W];
   assign mem_wdata = wb_head[DATA_W-1:0];

   assign st_wr_en   = fetch_beat || (wb_push && hit);
   assign st_wr_wsel = fetch_beat ? fill_cnt_q : wsel;
   assign st_wr_data = fetch_beat ? mem_rdata : cpu_wdata;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_LOOKUP:     if (is_read && !hit) state_d = ST_DRAIN;
         ST_DRAIN:      if (wb_empty)        state_d = ST_FETCH_REQ;
         ST_FETCH_REQ:  if (mem_gnt)         state_d = ST_FETCH_DATA;
         ST_FETCH_DATA: if (last_beat)       state_d = ST_LOOKUP;
         default:                            state_d = ST_LOOKUP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_LOOKUP;
         fill_cnt_q <= '0;
      end else begin
         state_q <= state_d;
         if (fetch_req)       fill_cnt_q <= '0;
         else if (fetch_beat) fill_cnt_q <= fill_cnt_q + 1'b1;
      end
   end

   dm_line_store #(
      .LINES (LINES),
      .WORDS (WORDS),
      .DATA_W(DATA_W),
      .TAG_W (TAG_W)
   ) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (idx),
      .rd_wsel (wsel),
      .rd_valid(line_valid),
      .rd_tag  (line_tag),
      .rd_data (cpu_rdata),
      .wr_en   (st_wr_en),
      .wr_idx  (idx),
      .wr_wsel (st_wr_wsel),
      .wr_data (st_wr_data),
      .fill_en (last_beat),
      .fill_tag(tag)
   );

   wt_queue #(
      .ENTRY_W(ENTRY_W),
      .DEPTH  (WB_DEPTH)
   ) i_wbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (wb_push),
      .push_data({cpu_addr, cpu_wdata}),
      .pop      (wb_pop),
      .head     (wb_head),
      .empty    (wb_empty),
      .full     (wb_full)
   );
endmodule

// File: rtl/dm_wt_cache_chk.sv
module dm_wt_cache_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_gnt,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rvalid,
   input logic              wb_full,
   input logic              wb_empty
);
   // R9: a refill read never overtakes a queued write
   a_r9_drain_first: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> wb_empty);

   // R10: a write facing a full queue is held off
   a_r10_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && wb_full) |-> !cpu_ready);

   // R3: the processor stays stalled while refill words arrive
   a_r3_stall_during_fill: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rvalid |-> !cpu_ready);

   // R11: an ungranted memory request is held unchanged
   a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R1: with the queue empty and no access, the memory port is idle
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_empty && !cpu_req && cpu_ready) |-> !mem_req);
endmodule

bind dm_wt_cache dm_wt_cache_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_we    (cpu_we),
   .cpu_ready (cpu_ready),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_gnt   (mem_gnt),
   .mem_addr  (mem_addr),
   .mem_rvalid(mem_rvalid),
   .wb_full   (wb_full),
   .wb_empty  (wb_empty)
);

// File: tb/test_dm_wt_cache.sv
module test_dm_wt_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic        cpu_ready;
   logic [31:0] cpu_rdata;
   logic        mem_req, mem_we, mem_gnt, mem_rvalid;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   always #2 clk = ~clk;

   dm_wt_cache i_dm_wt_cache (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   int checks = 0, errors = 0;
   int writes_done = 0;
   int mem_wr_log = 0;
   int fetch_wr_snap = 0;
   logic [31:0] last_wr_addr = '0, last_wr_data = '0;
   logic [31:0] ref_mem [logic [31:0]];
   logic [31:0] mem_store [logic [31:0]];
   logic [31:0] exp_q [$];
   string       tag_q [$];

   function automatic logic [31:0] init_word(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h1357_2468;
   endfunction

   function automatic logic [31:0] ref_rd(input logic [31:0] a);
      return ref_mem.exists(a) ? ref_mem[a] : init_word(a);
   endfunction

   function automatic logic [31:0] mem_rd(input logic [31:0] a);
      return mem_store.exists(a) ? mem_store[a] : init_word(a);
   endfunction

   // memory model: 1 accept cycle, then per word 15 wait cycles + 1 transfer
   int          mst = 0;
   int          mcnt = 0;
   int          mword = 0;
   logic [31:0] mbase = '0, mrd = '0;
   assign mem_gnt    = (mst == 0);
   assign mem_rvalid = (mst == 1) && (mcnt == 0);
   assign mem_rdata  = mrd;

   always @(posedge clk) begin
      if (!rst_n) begin
         mst <= 0;
      end else begin
         case (mst)
            0: if (mem_req) begin
               if (mem_we) begin
                  mem_store[mem_addr] = mem_wdata;
                  mem_wr_log = mem_wr_log + 1;
                  last_wr_addr = mem_addr;
                  last_wr_data = mem_wdata;
                  mst  <= 2;
                  mcnt <= 15;
               end else begin
                  fetch_wr_snap = mem_wr_log;
                  mst   <= 1;
                  mcnt  <= 15;
                  mword <= 0;
                  mbase <= mem_addr;
                  mrd   <= mem_rd(mem_addr);
               end
            end
            1: if (mcnt != 0) mcnt <= mcnt - 1;
               else if (mword == 3) mst <= 0;
               else begin
                  mword <= mword + 1;
                  mcnt  <= 15;
                  mrd   <= mem_rd(mbase + 32'((mword + 1) * 4));
               end
            2: if (mcnt != 0) mcnt <= mcnt - 1;
               else mst <= 0;
            default: mst <= 0;
         endcase
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // driver: one access; pushes the expected read value for the monitor
   task automatic xfer(input bit we, input logic [31:0] a, input logic [31:0] d,
                       input string req, output int stalls);
      if (!we) begin
         exp_q.push_back(ref_rd(a));
         tag_q.push_back(req);
      end
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      #1;
      stalls = 0;
      while (!cpu_ready) begin
         @(negedge clk);
         #1;
         stalls++;
      end
      @(posedge clk);
      if (we) begin
         ref_mem[a] = d;
         writes_done++;
      end
      #1;
      cpu_req = 1'b0;
   endtask

   // monitor: compares completed reads against the scoreboard
   always begin
      @(negedge clk);
      #1;
      if (rst_n && cpu_req && !cpu_we && cpu_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R3", "unexpected read completion", cpu_rdata, 32'h0);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(cpu_rdata == e, t, $sformatf("read data @%0h", cpu_addr), cpu_rdata, e);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   localparam logic [31:0] A0 = 32'h0000_1230;
   localparam logic [31:0] B0 = 32'h0000_5230;  // same index, tag +1
   localparam logic [31:0] C0 = 32'h8000_1230;  // same index, tag bit 31 only
   localparam logic [31:0] D0 = 32'h0000_1670;  // never loaded line
   localparam logic [31:0] E0 = 32'h0000_3FF0;  // index 1023

   initial begin
      int s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1: reset state
      check(cpu_ready == 1'b1, "R1", "ready after reset", 32'(cpu_ready), 32'h1);
      check(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'h0);

      // R3: compulsory miss with exact refill timing
      xfer(1'b0, A0, '0, "R3", s);
      check(s == 67, "R3", "cold miss stall cycles", 32'(s), 32'd67);

      // R4: other words of the refilled line hit
      for (int w = 1; w < 4; w++) begin
         xfer(1'b0, A0 + 32'(w * 4), '0, "R4", s);
         check(s == 0, "R4", "same-line hit stall", 32'(s), 32'h0);
      end
      xfer(1'b0, A0, '0, "R2", s);
      check(s == 0, "R2", "repeat read hit stall", 32'(s), 32'h0);

      // R5 / R2: index conflicts evict
      xfer(1'b0, B0, '0, "R5", s);
      check(s == 67, "R5", "conflict miss stall", 32'(s), 32'd67);
      xfer(1'b0, A0 + 32'h8, '0, "R5", s);
      check(s == 67, "R5", "evicted line misses", 32'(s), 32'd67);
      xfer(1'b0, C0, '0, "R2", s);
      check(s == 67, "R2", "tag bit 31 alone misses", 32'(s), 32'd67);
      xfer(1'b0, A0, '0, "R5", s);
      check(s == 67, "R5", "line evicted by bit-31 tag", 32'(s), 32'd67);

      // R6 / R7: write hit, then read back, then memory holds it
      xfer(1'b1, A0 + 32'h4, 32'hCAFE_0001, "R6", s);
      check(s == 0, "R6", "write hit stall", 32'(s), 32'h0);
      xfer(1'b0, A0 + 32'h4, '0, "R6", s);
      check(s == 0, "R6", "read after write hit stall", 32'(s), 32'h0);
      repeat (40) @(negedge clk);
      check(last_wr_addr == A0 + 32'h4, "R7", "memory write address", last_wr_addr, A0 + 32'h4);
      check(last_wr_data == 32'hCAFE_0001, "R7", "memory write data", last_wr_data, 32'hCAFE_0001);

      // R8 / R9: write miss does not allocate; refill waits for the queue
      xfer(1'b1, D0 + 32'h4, 32'hBEEF_0002, "R8", s);
      xfer(1'b0, D0 + 32'h4, '0, "R8", s);
      check(s >= 67, "R8", "read after write miss still misses", 32'(s), 32'd67);
      check(fetch_wr_snap == writes_done, "R9", "writes drained before refill",
            32'(fetch_wr_snap), 32'(writes_done));

      // R10: queue fills after five back-to-back writes
      repeat (40) @(negedge clk);
      for (int k = 0; k < 6; k++) begin
         xfer(1'b1, 32'h0002_0000 + 32'(k * 16), 32'h7700_0000 + 32'(k), "R10", s);
         if (k < 5) check(s == 0, "R10", $sformatf("write %0d stall", k), 32'(s), 32'h0);
         else       check(s > 0, "R10", "sixth write stalls", 32'(s), 32'h1);
      end
      repeat (150) @(negedge clk);
      check(mem_wr_log == writes_done, "R7", "all writes reached memory",
            32'(mem_wr_log), 32'(writes_done));
      for (int k = 0; k < 6; k++) begin
         logic [31:0] a;
         a = 32'h0002_0000 + 32'(k * 16);
         check(mem_rd(a) == ref_rd(a), "R7", $sformatf("memory word %0d", k), mem_rd(a), ref_rd(a));
      end

      // R12: last index
      xfer(1'b0, E0, '0, "R12", s);
      check(s == 67, "R12", "last index miss stall", 32'(s), 32'd67);
      xfer(1'b0, E0 + 32'hC, '0, "R12", s);
      check(s == 0, "R12", "last index last word hit", 32'(s), 32'h0);

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R3", "scoreboard drained", 32'(exp_q.size()), 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule